// File: doc/BRIEF.md
# Power-Up Recall Sequencer

This block controls the automatic reload of a battery-less memory array from its nonvolatile shadow after the supply has been lost or was never there. Two comparator flags feed it. One says the supply is under the switch threshold. The other says the storage capacitor has charged back above its threshold. Each low-supply event arms a pending reload. The reload itself starts only when the capacitor is good again and the supply is no longer low.

A reload runs in two timed phases. In the first, the array is wiped. In the second, the saved contents are copied back in. Both phases are driven by strobes to the memory model, and the chip stays disabled until the reload has finished. A new low-supply event during a reload aborts it and leaves the request armed.

When the array is released for normal use, a write that is still being driven is not honoured. The host must drop either the chip select or the write request, and then assert it again, before a write is granted.

Top module: `pwrup_recall_ctrl`

## Requirements
- R1: A pending reload is armed by reset and by every clock cycle in which `supply_low` is 1. It is cleared only when a reload completes. With nothing pending, `cap_ok` has no effect while the block is running.
- R2: When a reload is pending, `supply_low` is 0 and `cap_ok` is 1, the block enters the wipe phase at the next clock edge. In that same first wipe cycle, `rcl_start` is 1 for exactly one cycle.
- R3: `chip_disable` is 1 in every state except running. It falls exactly CLEAR_CYCLES + COPY_CYCLES cycles after the start cycle.
- R4: `rcl_clear` is 1 for exactly CLEAR_CYCLES cycles. It is followed at once by `rcl_copy`, which is 1 for exactly COPY_CYCLES cycles. The two are never 1 together.
- R5: If `chip_sel` and `wr_req` are both 1 in the cycle the block enters running, `wr_grant` stays 0 until a cycle in which at least one of them is 0 has been clocked in.
- R6: A cycle with `supply_low` at 1 during the wipe or copy phase, or while running, sends the block back to waiting at the next edge. Both phase strobes drop, and the reload remains pending.
- R7: While `rst_n` is 0, `chip_disable` is 1 and `rcl_start`, `rcl_clear`, `rcl_copy` and `wr_grant` are 0. Reset is applied asynchronously and released through a two-flop synchronizer.
- R8: `wr_grant` is 1 only while running with `chip_sel` and `wr_req` both 1 and no suppression active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_low | input | 1 | Supply below switch threshold |
| cap_ok | input | 1 | Storage capacitor above threshold |
| chip_sel | input | 1 | Host chip select, active high |
| wr_req | input | 1 | Host write strobe, active high |
| chip_disable | output | 1 | Array unavailable to the host |
| rcl_start | output | 1 | One-cycle pulse at reload start |
| rcl_clear | output | 1 | Wipe phase strobe |
| rcl_copy | output | 1 | Copy phase strobe |
| wr_grant | output | 1 | Host write permitted this cycle |

## Verification
The reload is exercised in three ways:
- After a clean supply dip, holding a write across the end of the reload. This separates correct phase lengths from off-by-one counts and shows that the write is held off.
- With the supply dropping again during the wipe phase and, in a separate run, during the copy phase. These show that the abort works and that the request survives it.
- With the capacitor flag high while nothing is pending, which shows the request is cleared on completion.

The held write is released once through the write strobe and once through the chip select, so the two clearing paths are told apart. An asynchronous reset taken while running checks the power-up arming.

// File: rtl/recall_pkg.sv
package recall_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_COPY  = 2'd2,
    ST_RUN   = 2'd3
  } rcl_state_e;
endpackage

// File: rtl/rcl_rst_sync.sv
module rcl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/rcl_pend_latch.sv
module rcl_pend_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (set_i)      pend_d = 1'b1;
    else if (clr_i) pend_d = 1'b0;
  end

  // power-up counts as a supply loss: the request starts armed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b1;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R1
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);
endmodule

// File: rtl/rcl_phase_timer.sv
module rcl_phase_timer #(
  parameter int CLEAR_CYCLES = 4,
  parameter int COPY_CYCLES  = 6,
  localparam int MAXC = (CLEAR_CYCLES > COPY_CYCLES) ? CLEAR_CYCLES : COPY_CYCLES,
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic restart_i,
  input  logic copy_i,
  output logic last_o
);
  localparam logic [CW-1:0] CLR_LAST = CW'(CLEAR_CYCLES - 1);
  localparam logic [CW-1:0] CPY_LAST = CW'(COPY_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = busy_i || restart_i || (cnt_q != '0);

  always_comb begin
    if (restart_i || !busy_i) cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = busy_i && (cnt_q == (copy_i ? CPY_LAST : CLR_LAST));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (cnt_q <= (copy_i ? CPY_LAST : CLR_LAST)));
endmodule

// File: rtl/rcl_write_guard.sv
module rcl_write_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic end_i,
  input  logic sel_i,
  input  logic wr_i,
  output logic grant_o
);
  logic block_q, block_d;
  logic held;

  assign held = sel_i && wr_i;

  always_comb begin
    if (end_i) block_d = held;
    else       block_d = block_q && held;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) block_q <= 1'b0;
    else        block_q <= block_d;
  end

  assign grant_o = run_i && held && !block_q;

  // R5
  held_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_i && held) |=> (!held || !grant_o));
endmodule

// File: rtl/pwrup_recall_ctrl.sv
module pwrup_recall_ctrl
  import recall_pkg::*;
#(
  parameter int CLEAR_CYCLES = 4,
  parameter int COPY_CYCLES  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low,
  input  logic cap_ok,
  input  logic chip_sel,
  input  logic wr_req,
  output logic chip_disable,
  output logic rcl_start,
  output logic rcl_clear,
  output logic rcl_copy,
  output logic wr_grant
);
  logic       rst_n_s;
  rcl_state_e state_q, state_d;
  logic       pend, phase_last, busy, restart, recall_end;
  logic       start_q, start_d;

  rcl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT:  if (pend && cap_ok && !supply_low) state_d = ST_CLEAR;
      ST_CLEAR: if (supply_low) state_d = ST_WAIT;
                else if (phase_last) state_d = ST_COPY;
      ST_COPY:  if (supply_low) state_d = ST_WAIT;
                else if (phase_last) state_d = ST_RUN;
      ST_RUN:   if (supply_low) state_d = ST_WAIT;
      default:  state_d = ST_WAIT;
    endcase
  end

  assign busy       = (state_q == ST_CLEAR) || (state_q == ST_COPY);
  assign restart    = (state_d != state_q);
  assign recall_end = (state_q == ST_COPY) && (state_d == ST_RUN);
  assign start_d    = (state_q == ST_WAIT) && (state_d == ST_CLEAR);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_WAIT;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  rcl_pend_latch u_pend (
    .clk(clk), .rst_n(rst_n_s),
    .set_i(supply_low), .clr_i(recall_end), .pend_o(pend)
  );

  rcl_phase_timer #(.CLEAR_CYCLES(CLEAR_CYCLES), .COPY_CYCLES(COPY_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n_s),
    .busy_i(busy), .restart_i(restart),
    .copy_i(state_q == ST_COPY), .last_o(phase_last)
  );

  rcl_write_guard u_wg (
    .clk(clk), .rst_n(rst_n_s),
    .run_i(state_q == ST_RUN), .end_i(recall_end),
    .sel_i(chip_sel), .wr_i(wr_req), .grant_o(wr_grant)
  );

  assign chip_disable = (state_q != ST_RUN);
  assign rcl_clear    = (state_q == ST_CLEAR);
  assign rcl_copy     = (state_q == ST_COPY);
  assign rcl_start    = start_q;

  // R2
  start_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rcl_start |-> (rcl_clear && $rose(rcl_clear)));
  // R6
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (supply_low && busy) |=> (!rcl_clear && !rcl_copy && chip_disable));
  // R8
  grant_run_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_grant |-> (!chip_disable && chip_sel && wr_req));
  // R4
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($fell(rcl_clear) && !supply_low && !$past(supply_low)) |-> rcl_copy);
endmodule

// File: tb/sim_pwrup_recall_ctrl.sv
`timescale 1ns/1ps
module sim_pwrup_recall_ctrl;
  logic clk = 1'b0;
  logic rst_n, supply_low, cap_ok, chip_sel, wr_req;
  logic chip_disable, rcl_start, rcl_clear, rcl_copy, wr_grant;
  int   nchk = 0, nerr = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  pwrup_recall_ctrl #(.CLEAR_CYCLES(2), .COPY_CYCLES(3)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .cap_ok(cap_ok),
    .chip_sel(chip_sel), .wr_req(wr_req), .chip_disable(chip_disable),
    .rcl_start(rcl_start), .rcl_clear(rcl_clear), .rcl_copy(rcl_copy),
    .wr_grant(wr_grant)
  );

  // {supply_low, cap_ok, chip_sel, wr_req, disable, clear, copy, start, grant}
  localparam logic [8:0] VEC [0:30] = '{
    9'b1000_10000, // R1 low supply, armed
    9'b0000_10000, // cap still low
    9'b0100_11010, // R2 start, wipe
    9'b0111_11000,
    9'b0111_10100, // copy
    9'b0111_10100,
    9'b0111_10100,
    9'b0111_00000, // R5 run, held write blocked
    9'b0111_00000,
    9'b0110_00000, // write strobe released
    9'b0111_00001, // grant
    9'b0100_00000,
    9'b1100_10000, // R1 dip while running
    9'b0100_11010,
    9'b1100_10000, // R6 abort in wipe
    9'b0000_10000,
    9'b0100_11010,
    9'b0100_11000,
    9'b0100_10100,
    9'b0111_10100, // no grant while disabled
    9'b0111_10100,
    9'b0111_00000, // R5 blocked
    9'b0101_00000, // select released
    9'b0111_00001,
    9'b0100_00000, // R1 nothing pending, stays running
    9'b1100_10000,
    9'b0100_11010,
    9'b0100_11000,
    9'b0100_10100,
    9'b1100_10000, // R6 abort in copy
    9'b0100_11010  // request survived
  };

  task automatic chk(string tag, string what, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL R3 watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; supply_low = 1'b0; cap_ok = 1'b0; chip_sel = 1'b0; wr_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7", "disable", chip_disable, 1'b1);
    chk("R7", "clear", rcl_clear, 1'b0);
    chk("R7", "copy", rcl_copy, 1'b0);
    chk("R7", "start", rcl_start, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "idle disable", chip_disable, 1'b1);

    for (int i = 0; i < 31; i++) begin
      {supply_low, cap_ok, chip_sel, wr_req} = VEC[i][8:5];
      @(negedge clk);
      chk((i == 14 || i == 29) ? "R6" : (i == 0 || i == 12 || i == 25 || i == 24) ? "R1" : "R3",
          $sformatf("v%0d disable", i), chip_disable, VEC[i][4]);
      chk("R4", $sformatf("v%0d clear", i), rcl_clear, VEC[i][3]);
      chk("R4", $sformatf("v%0d copy", i), rcl_copy, VEC[i][2]);
      chk("R2", $sformatf("v%0d start", i), rcl_start, VEC[i][1]);
      chk((i == 7 || i == 8 || i == 21) ? "R5" : "R8",
          $sformatf("v%0d grant", i), wr_grant, VEC[i][0]);
    end

    // finish the pending reload, then reset while running
    supply_low = 1'b0; cap_ok = 1'b1; chip_sel = 1'b1; wr_req = 1'b1;
    repeat (6) @(negedge clk);
    chk("R5", "held across end", wr_grant, 1'b0);
    chk("R3", "running", chip_disable, 1'b0);
    chip_sel = 1'b0; wr_req = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    chk("R7", "async disable", chip_disable, 1'b1);
    chk("R7", "async grant", wr_grant, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2", "no start during sync", rcl_start, 1'b0);
    @(negedge clk);
    chk("R1", "armed by reset", rcl_start, 1'b1);
    chk("R4", "wipe after reset", rcl_clear, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule